// File: doc/BRIEF.md
# Nanosecond Real-Time Clock with Alarm

This block is a real-time clock peripheral for a simple 32-bit register bus. It holds a free-running 64-bit count of nanoseconds that moves forward by a fixed number of nanoseconds on every clock cycle. Software can load that count, read it back, and program a 64-bit alarm. When the count reaches the alarm, the block raises an interrupt request. An enable bit gates the request, and software drops it by writing an acknowledge register.

The 64-bit quantities travel as two 32-bit words, and the order of access matters. Reading the low time word also copies the high word into a holding register, so a later high-word read returns a value that matches the low word already read. Loading the time takes two writes: the high word is staged first, and the low-word write then commits both halves. Writing the upper alarm word only stores it. Writing the lower alarm word stores it and arms the alarm.

The bus is a single-cycle select/write-enable interface. Read data is combinational in the cycle the read is presented. Write effects and read side effects take place on the clock edge that ends the access.

Top module: `ns_rtc`

## Requirements
- R1: While reset is held, every register reads zero and `irq` is low.
- R2: Outside a time-low write, the time count grows by `NS_STEP` on every clock edge and wraps modulo 2^64.
- R3: A read at byte offset 0x00 returns the live low 32 bits of the time count. On the edge that ends that read, the live upper 32 bits are copied into a holding register. A read at offset 0x04 returns the holding register, not the live upper bits.
- R4: A write at offset 0x04 stages an upper word and leaves the count unchanged. A write at offset 0x00 loads the count with {staged word, written word}.
- R5: A write at offset 0x0C stores the upper alarm word without arming. A write at offset 0x08 stores the lower alarm word and arms the alarm. Both words read back at their own offsets.
- R6: A read at offset 0x18 returns 1 while the alarm is armed and 0 otherwise.
- R7: On an edge where the alarm is armed and the count is greater than or equal to the alarm value, the alarm disarms and a sticky pending flag sets. This does not happen if the same cycle writes the lower alarm word or cancels the alarm.
- R8: A write at offset 0x14 with bit 0 set disarms the alarm. The same write with bit 0 clear has no effect.
- R9: Bit 0 of offset 0x10 is the interrupt enable and reads back. `irq` equals pending AND enable, so a pending flag raised while the enable is off shows on `irq` once the enable is set.
- R10: A write at offset 0x1C with bit 0 set clears the pending flag. A firing alarm in the same cycle wins and keeps it set.
- R11: Reads of offsets 0x14 and 0x1C return zero. Writes at offset 0x18 change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_sel | input | 1 | Access valid this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address; bits [4:2] select the word |
| bus_wdata | input | WORD_W | Write data |
| bus_rdata | output | WORD_W | Read data, combinational, zero when not reading |
| irq | output | 1 | Alarm interrupt request |

## Verification
Read data is due in the same cycle as the read, so the bench presents each access half a period before the edge and samples `bus_rdata` 1 ns later. Every write, the holding-register capture and an alarm firing become visible in the cycle after the edge that performs them. The bench's reference model therefore advances on the same edge as the design, and each check compares against the model state as it stands after the previous edge. `irq` follows the pending flag and the enable combinationally, so it is checked during every access against the model's pending and enable values from that same cycle.

// File: rtl/rtc_pkg.sv
package rtc_pkg;

   // Word index = byte offset / 4; software relies on these positions.
   typedef enum logic [2:0] {
      IDX_TLO   = 3'd0,
      IDX_THI   = 3'd1,
      IDX_ALO   = 3'd2,
      IDX_AHI   = 3'd3,
      IDX_IEN   = 3'd4,
      IDX_ACLR  = 3'd5,
      IDX_ASTAT = 3'd6,
      IDX_ICLR  = 3'd7
   } rtc_idx_e;

   typedef struct packed {
      logic tlo_wr;
      logic thi_wr;
      logic alo_wr;
      logic ahi_wr;
      logic ien_wr;
      logic cancel;
      logic ack;
      logic tlo_rd;
   } rtc_strobe_t;

endpackage

// File: rtl/rtc_decode.sv
module rtc_decode
   import rtc_pkg::*;
#(
   parameter int ADDR_W = 5
) (
   input  logic              sel,
   input  logic              we,
   input  logic [ADDR_W-1:0] addr,
   input  logic              wbit0,
   output logic [2:0]        idx,
   output logic              rd_hit,
   output rtc_strobe_t       stb
);

   logic in_range;

   generate
      if (ADDR_W > 5) begin : g_wide
         assign in_range = (addr[ADDR_W-1:5] == '0);
      end else begin : g_narrow
         assign in_range = 1'b1;
      end
   endgenerate

   assign idx = addr[4:2];

   logic wr_hit;
   assign wr_hit = sel & we & in_range;
   assign rd_hit = sel & ~we & in_range;

   always_comb begin
      stb        = '0;
      stb.tlo_wr = wr_hit & (idx == IDX_TLO);
      stb.thi_wr = wr_hit & (idx == IDX_THI);
      stb.alo_wr = wr_hit & (idx == IDX_ALO);
      stb.ahi_wr = wr_hit & (idx == IDX_AHI);
      stb.ien_wr = wr_hit & (idx == IDX_IEN);
      stb.cancel = wr_hit & (idx == IDX_ACLR) & wbit0;
      stb.ack    = wr_hit & (idx == IDX_ICLR) & wbit0;
      stb.tlo_rd = rd_hit & (idx == IDX_TLO);
   end

endmodule

// File: rtl/rtc_counter.sv
module rtc_counter #(
   parameter int WORD_W  = 32,
   parameter int TIME_W  = 64,
   parameter int NS_STEP = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ld_hi,
   input  logic              ld_lo,
   input  logic              snap,
   input  logic [WORD_W-1:0] wdata,
   output logic [TIME_W-1:0] now,
   output logic [WORD_W-1:0] held_hi
);

   localparam int HI_W = TIME_W - WORD_W;
   localparam logic [TIME_W-1:0] STEP_V = TIME_W'(NS_STEP);

   logic [HI_W-1:0]   stage_q;
   logic [TIME_W-1:0] now_q;
   logic [HI_W-1:0]   held_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         stage_q <= '0;
         now_q   <= '0;
         held_q  <= '0;
      end else begin
         if (ld_hi) stage_q <= wdata[HI_W-1:0];
         if (ld_lo) now_q <= {stage_q, wdata};
         else       now_q <= now_q + STEP_V;
         if (snap)  held_q <= now_q[TIME_W-1:WORD_W];
      end
   end

   assign now     = now_q;
   assign held_hi = WORD_W'(held_q);

endmodule

// File: rtl/rtc_alarm.sv
module rtc_alarm #(
   parameter int WORD_W = 32,
   parameter int TIME_W = 64
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              set_hi,
   input  logic              set_lo,
   input  logic              cancel,
   input  logic              ack,
   input  logic [WORD_W-1:0] wdata,
   input  logic [TIME_W-1:0] now,
   output logic [TIME_W-1:0] alarm,
   output logic              armed,
   output logic              pending
);

   localparam int HI_W = TIME_W - WORD_W;

   logic [HI_W-1:0]   a_hi_q;
   logic [WORD_W-1:0] a_lo_q;
   logic              armed_q;
   logic              pend_q;
   logic              reached;
   logic              fire;

   assign alarm   = {a_hi_q, a_lo_q};
   assign reached = armed_q & (now >= alarm);
   // A fresh arm or a cancel in the same cycle overrides a match.
   assign fire    = reached & ~set_lo & ~cancel;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         a_hi_q  <= '0;
         a_lo_q  <= '0;
         armed_q <= 1'b0;
         pend_q  <= 1'b0;
      end else begin
         if (set_hi) a_hi_q <= wdata[HI_W-1:0];
         if (set_lo) a_lo_q <= wdata;
         if (set_lo)       armed_q <= 1'b1;
         else if (cancel)  armed_q <= 1'b0;
         else if (reached) armed_q <= 1'b0;
         pend_q <= fire | (pend_q & ~ack);
      end
   end

   assign armed   = armed_q;
   assign pending = pend_q;

endmodule

// File: rtl/ns_rtc.sv
module ns_rtc
   import rtc_pkg::*;
#(
   parameter int ADDR_W  = 5,
   parameter int WORD_W  = 32,
   parameter int TIME_W  = 64,
   parameter int NS_STEP = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_sel,
   input  logic              bus_we,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [WORD_W-1:0] bus_wdata,
   output logic [WORD_W-1:0] bus_rdata,
   output logic              irq
);

   generate
      if (TIME_W != 2 * WORD_W) begin : g_bad_time
         $error("TIME_W must be twice WORD_W");
      end
      if (ADDR_W < 5) begin : g_bad_addr
         $error("ADDR_W must cover eight word registers");
      end
      if (NS_STEP < 1) begin : g_bad_step
         $error("NS_STEP must be positive");
      end
   endgenerate

   rtc_strobe_t       stb;
   logic [2:0]        reg_idx;
   logic              rd_hit;
   logic [TIME_W-1:0] time_q;
   logic [WORD_W-1:0] hold_q;
   logic [TIME_W-1:0] alarm_q;
   logic              armed;
   logic              pending;
   logic              irq_en;

   rtc_decode #(.ADDR_W(ADDR_W)) u_dec (
      .sel    (bus_sel),
      .we     (bus_we),
      .addr   (bus_addr),
      .wbit0  (bus_wdata[0]),
      .idx    (reg_idx),
      .rd_hit (rd_hit),
      .stb    (stb)
   );

   rtc_counter #(.WORD_W(WORD_W), .TIME_W(TIME_W), .NS_STEP(NS_STEP)) u_cnt (
      .clk     (clk),
      .rst_n   (rst_n),
      .ld_hi   (stb.thi_wr),
      .ld_lo   (stb.tlo_wr),
      .snap    (stb.tlo_rd),
      .wdata   (bus_wdata),
      .now     (time_q),
      .held_hi (hold_q)
   );

   rtc_alarm #(.WORD_W(WORD_W), .TIME_W(TIME_W)) u_alm (
      .clk     (clk),
      .rst_n   (rst_n),
      .set_hi  (stb.ahi_wr),
      .set_lo  (stb.alo_wr),
      .cancel  (stb.cancel),
      .ack     (stb.ack),
      .wdata   (bus_wdata),
      .now     (time_q),
      .alarm   (alarm_q),
      .armed   (armed),
      .pending (pending)
   );

   always_ff @(posedge clk) begin
      if (!rst_n)          irq_en <= 1'b0;
      else if (stb.ien_wr) irq_en <= bus_wdata[0];
   end

   assign irq = pending & irq_en;

   always_comb begin
      bus_rdata = '0;
      if (rd_hit) begin
         case (reg_idx)
            IDX_TLO:   bus_rdata = time_q[WORD_W-1:0];
            IDX_THI:   bus_rdata = hold_q;
            IDX_ALO:   bus_rdata = alarm_q[WORD_W-1:0];
            IDX_AHI:   bus_rdata = alarm_q[TIME_W-1:WORD_W];
            IDX_IEN:   bus_rdata = WORD_W'(irq_en);
            IDX_ASTAT: bus_rdata = WORD_W'(armed);
            default:   bus_rdata = '0;
         endcase
      end
   end

endmodule

// File: rtl/rtc_checks.sv
module rtc_checks #(
   parameter int WORD_W  = 32,
   parameter int TIME_W  = 64,
   parameter int NS_STEP = 4
) (
   input logic              clk,
   input logic              rst_n,
   input logic              sel,
   input logic              we,
   input logic [2:0]        idx,
   input logic              wbit0,
   input logic [TIME_W-1:0] time_q,
   input logic [WORD_W-1:0] hold_q,
   input logic [TIME_W-1:0] alarm_q,
   input logic              armed,
   input logic              pending,
   input logic              irq_en,
   input logic              irq
);

   logic wr_tlo, rd_tlo, wr_alo, wr_cancel, wr_ack;
   assign wr_tlo    = sel & we & (idx == 3'd0);
   assign rd_tlo    = sel & ~we & (idx == 3'd0);
   assign wr_alo    = sel & we & (idx == 3'd2);
   assign wr_cancel = sel & we & (idx == 3'd5) & wbit0;
   assign wr_ack    = sel & we & (idx == 3'd7) & wbit0;

   AST_TIME_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_tlo |=> time_q == $past(time_q) + TIME_W'(NS_STEP)); // R2
   AST_SNAPSHOT: assert property (@(posedge clk) disable iff (!rst_n)
      rd_tlo |=> hold_q == $past(time_q[TIME_W-1:WORD_W])); // R3
   AST_ARM_ON_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      wr_alo |=> armed); // R5
   AST_FIRE: assert property (@(posedge clk) disable iff (!rst_n)
      (armed && time_q >= alarm_q && !wr_alo && !wr_cancel) |=> (pending && !armed)); // R7
   AST_CANCEL: assert property (@(posedge clk) disable iff (!rst_n)
      wr_cancel |=> !armed); // R8
   AST_IRQ_GATED: assert property (@(posedge clk) disable iff (!rst_n)
      !irq_en |-> !irq); // R9
   AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_ack && !armed) |=> !pending); // R10

endmodule

bind ns_rtc rtc_checks #(.WORD_W(WORD_W), .TIME_W(TIME_W), .NS_STEP(NS_STEP)) u_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .sel     (bus_sel),
   .we      (bus_we),
   .idx     (reg_idx),
   .wbit0   (bus_wdata[0]),
   .time_q  (time_q),
   .hold_q  (hold_q),
   .alarm_q (alarm_q),
   .armed   (armed),
   .pending (pending),
   .irq_en  (irq_en),
   .irq     (irq)
);

// File: tb/sim_ns_rtc.sv
`timescale 1ns/1ps
module sim_ns_rtc;

   localparam int STEP = 4;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        sel = 1'b0;
   logic        we = 1'b0;
   logic [4:0]  addr = '0;
   logic [31:0] wd = '0;
   logic [31:0] rdata;
   logic        irq;

   int n_chk = 0;
   int n_fail = 0;

   always #2 clk = ~clk;

   ns_rtc #(.ADDR_W(5), .WORD_W(32), .TIME_W(64), .NS_STEP(STEP)) u0 (
      .clk(clk), .rst_n(rst_n), .bus_sel(sel), .bus_we(we),
      .bus_addr(addr), .bus_wdata(wd), .bus_rdata(rdata), .irq(irq)
   );

   // Reference model, advanced on the same edge as the design.
   logic [63:0] m_time, m_alarm;
   logic [31:0] m_stage, m_hold;
   logic        m_armed, m_pend, m_en;
   logic        t_hit, t_fire, t_alo, t_cancel;
   logic [2:0]  cur_idx;
   assign cur_idx = addr[4:2];

   always @(posedge clk) begin
      if (!rst_n) begin
         m_time = '0; m_alarm = '0; m_stage = '0; m_hold = '0;
         m_armed = 0; m_pend = 0; m_en = 0;
      end else begin
         t_alo    = sel && we && cur_idx == 3'd2;
         t_cancel = sel && we && cur_idx == 3'd5 && wd[0];
         t_hit    = m_armed && (m_time >= m_alarm);
         t_fire   = t_hit && !t_alo && !t_cancel;
         if (sel && !we && cur_idx == 3'd0) m_hold = m_time[63:32];
         if (t_alo) m_armed = 1;
         else if (t_cancel || t_hit) m_armed = 0;
         m_pend = t_fire || (m_pend && !(sel && we && cur_idx == 3'd7 && wd[0]));
         if (sel && we) begin
            case (cur_idx)
               3'd1: m_stage = wd;
               3'd2: m_alarm[31:0] = wd;
               3'd3: m_alarm[63:32] = wd;
               3'd4: m_en = wd[0];
               default: ;
            endcase
         end
         if (sel && we && cur_idx == 3'd0) m_time = {m_stage, wd};
         else m_time = m_time + 64'(STEP);
      end
   end

   function automatic logic [31:0] exp_rd(input logic [2:0] i);
      case (i)
         3'd0: return m_time[31:0];
         3'd1: return m_hold;
         3'd2: return m_alarm[31:0];
         3'd3: return m_alarm[63:32];
         3'd4: return {31'd0, m_en};
         3'd6: return {31'd0, m_armed};
         default: return 32'd0;
      endcase
   endfunction

   task automatic check(input logic [63:0] act, input logic [63:0] exp, input string rq);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", rq, act, exp);
      end
   endtask

   function automatic string tag_of(input logic [2:0] i);
      case (i)
         3'd0: return "R2/R3 time low";
         3'd1: return "R3 held high";
         3'd2, 3'd3: return "R5 alarm readback";
         3'd4: return "R9 enable readback";
         3'd6: return "R6 status";
         default: return "R11 clear reads zero";
      endcase
   endfunction

   // One access: drive at negedge, sample 1 ns later, effect at next posedge.
   task automatic acc(input logic w, input logic [2:0] i, input logic [31:0] d);
      @(negedge clk);
      sel = 1; we = w; addr = {i, 2'b00}; wd = d;
      #1;
      if (!w) check(64'(rdata), 64'(exp_rd(i)), tag_of(i));
      check(64'(irq), 64'(m_pend & m_en), "R9 irq gating");
      @(posedge clk);
      #0.5 sel = 0; we = 0;
   endtask

   task automatic rd_lit(input logic [2:0] i, input logic [31:0] lit, input string rq);
      @(negedge clk);
      sel = 1; we = 0; addr = {i, 2'b00};
      #1;
      check(64'(rdata), 64'(lit), rq);
      @(posedge clk);
      #0.5 sel = 0;
   endtask

   task automatic idle(input int n);
      for (int k = 0; k < n; k++) @(negedge clk);
   endtask

   initial begin : watchdog
      #(200000 * 4);
      n_fail++; n_chk++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin : main
      void'($urandom(32'd1234));
      // R1: state under reset
      repeat (3) @(posedge clk);
      @(negedge clk);
      sel = 1; we = 0;
      for (int i = 0; i < 8; i++) begin
         addr = 5'(i * 4);
         #0.2 check(64'(rdata), 0, "R1 reset read");
      end
      check(64'(irq), 0, "R1 reset irq");
      sel = 0;
      @(negedge clk); rst_n = 1;

      // R4: staged load, then R2 exact stepping
      acc(1, 3'd1, 32'h0000_0000);
      acc(1, 3'd0, 32'd1000);
      rd_lit(3'd0, 32'd1000, "R4 loaded low");
      rd_lit(3'd0, 32'd1000 + STEP, "R2 step");
      acc(1, 3'd1, 32'h0000_0077);   // stage only
      rd_lit(3'd0, 32'd1000 + 3 * STEP, "R4 stage leaves time");

      // R3: carry across low word after snapshot
      acc(1, 3'd1, 32'd5);
      acc(1, 3'd0, 32'hFFFF_FFF8);
      rd_lit(3'd0, 32'hFFFF_FFF8, "R3 low before wrap");
      idle(3);
      rd_lit(3'd1, 32'd5, "R3 held high after wrap");
      acc(0, 3'd0, 0);
      rd_lit(3'd1, 32'd6, "R3 fresh snapshot");

      // R5/R6/R7/R9/R10: alarm fires with irq disabled, then enabled
      acc(1, 3'd1, 0); acc(1, 3'd0, 0);
      acc(1, 3'd3, 0);
      acc(0, 3'd6, 0);
      rd_lit(3'd6, 0, "R5 high write does not arm");
      acc(1, 3'd2, 32'd60);
      rd_lit(3'd6, 1, "R6 armed status");
      rd_lit(3'd2, 32'd60, "R5 low readback");
      idle(20);
      rd_lit(3'd6, 0, "R7 disarmed after fire");
      check(64'(irq), 0, "R9 pending hidden while disabled");
      acc(1, 3'd4, 1);
      rd_lit(3'd4, 1, "R9 enable readback");
      check(64'(irq), 1, "R9 irq after enable");
      acc(1, 3'd7, 0);
      check(64'(irq), 1, "R10 ack bit0 clear ignored");
      acc(1, 3'd7, 1);
      #1 check(64'(irq), 0, "R10 ack clears");

      // R8: cancel
      acc(1, 3'd2, 32'd100000);
      acc(1, 3'd5, 0);
      rd_lit(3'd6, 1, "R8 cancel bit0 clear ignored");
      acc(1, 3'd5, 1);
      rd_lit(3'd6, 0, "R8 cancel disarms");
      idle(5);
      check(64'(irq), 0, "R8 no fire after cancel");

      // R11: status write ignored, clear regs read zero
      acc(1, 3'd6, 32'hFFFF_FFFF);
      rd_lit(3'd6, 0, "R11 status write ignored");
      rd_lit(3'd5, 0, "R11 alarm clear reads zero");
      rd_lit(3'd7, 0, "R11 irq clear reads zero");

      // Constrained random mix against the model
      for (int n = 0; n < 600; n++) begin
         logic [2:0]  i;
         logic        w;
         logic [31:0] d;
         i = 3'($urandom % 8);
         w = 1'($urandom % 2);
         case (i)
            3'd0: d = $urandom;
            3'd1: d = 32'($urandom % 3);
            3'd2: d = m_time[31:0] + 32'($urandom % 80);
            3'd3: d = m_time[63:32];
            default: d = 32'($urandom % 2);
         endcase
         acc(w, i, d);
         if ($urandom % 4 == 0) idle(1 + int'($urandom % 8));
      end

      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

endmodule